// File: doc/BRIEF.md
# Six-Channel Nested-Loop DMA Engine

This block moves 16-bit words from one memory-mapped location to another on behalf of six independent channels, with no processor in the data path. Each channel is set up through a small write-only configuration port: a source base, one or two destination bases, a burst length, a transfer count, and four signed address steps. Two steps apply between words of a burst. Two apply between bursts. Because the steps are separate and signed, data can be interleaved, reversed or spread into bins while it is copied.

A channel runs one burst each time it is triggered, either by a hardware line or by a software write. All channels share one datapath. That datapath drives a single-word master port with a valid/ready handshake: it reads the source word, then writes it to the destination. Pending channels take turns in round-robin order. Channel 0 can be set to preempt the others at any word boundary. When a channel's last burst ends, it pulses its own interrupt line. In ping-pong mode the channel then swaps its destination base and rearms itself.

Top module: `dma_nested6`

## Requirements
- R1: After reset `irq`, `ovf` and `m_valid` are all zero.
- R2: `cfg_field` codes: 0 source base, 1 destination base, 2 alternate destination, 3 burst size, 4 transfer count, 5/6 source/destination word step, 7/8 source/destination burst step, 9 control (bit0 run, bit1 ping-pong, bit2 priority boost, channel 0 only), 10 software trigger. A control write with run=1 arms the channel and reloads its pointers and counters. If the transfer count is 0 the channel stays unarmed, and triggers to an unarmed channel cause no bus activity.
- R3: One trigger moves exactly burst size + 1 words. Each word is a read at the current source followed by a write of the read data to the current destination.
- R4: Within a burst, after each word the source and destination advance by their signed (two's complement) word steps.
- R5: Each burst starts at the previous burst's starting addresses plus the signed burst steps.
- R6: When the burst that brings the remaining count to zero ends, the channel's `irq` bit is high for exactly one cycle. Without ping-pong the channel then ignores triggers.
- R7: A software trigger write (code 10) starts a burst exactly like a pulse on `trig_in`.
- R8: A trigger to a channel that is already pending or mid-burst sets that channel's `ovf` bit and adds no burst. `ovf` stays set until the next control write to that channel.
- R9: With no priority boost, several pending channels are served one whole burst at a time, in increasing index order starting after the channel that last finished a burst.
- R10: With the boost set, a pending channel 0 is taken at the next word boundary. The preempted channel then finishes its burst.
- R11: In ping-pong mode each completed transfer swaps the destination base between codes 1 and 2, reloads the source base and the count, and leaves the channel armed.
- R12: While `m_ready` is low, `m_valid`, `m_write`, `m_addr` and `m_wdata` hold steady and no word is lost.
- R13: At most one `irq` bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel addressed by the write |
| cfg_field | input | 4 | Field code (see R2) |
| cfg_wdata | input | 16 | Write data |
| trig_in | input | 6 | Per-channel hardware trigger pulses |
| m_valid | output | 1 | Master access request |
| m_write | output | 1 | 1 for a write, 0 for a read |
| m_addr | output | 16 | Access address |
| m_wdata | output | 16 | Write data |
| m_ready | input | 1 | Access accepted this cycle |
| m_rdata | input | 16 | Read data, valid with `m_ready` on a read |
| irq | output | 6 | Per-channel completion pulse |
| ovf | output | 6 | Per-channel sticky overflow flag |

## Verification
A trigger can reach a channel in the same cycle that the engine accepts the last write of that channel's burst. At that moment the pending bit is still set, so the trigger must count as an overflow and must not queue a new burst. The bench waits until it sees the last write on the port with `m_ready` high, then pulses the trigger in that cycle. It then expects `ovf` set, exactly one word moved and no further bus traffic. A second collision is a boosted channel 0 becoming pending in the same cycle as another channel's first write. The bench checks the resulting word order in its write log.

// File: rtl/dma6_pkg.sv
package dma6_pkg;
   typedef enum logic [3:0] {
      F_SRC    = 4'd0,
      F_DST    = 4'd1,
      F_DALT   = 4'd2,
      F_BSIZE  = 4'd3,
      F_TCOUNT = 4'd4,
      F_SBSTEP = 4'd5,
      F_DBSTEP = 4'd6,
      F_STSTEP = 4'd7,
      F_DTSTEP = 4'd8,
      F_CTRL   = 4'd9,
      F_TRIG   = 4'd10
   } cfg_field_e;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_RD   = 2'd1,
      S_WR   = 2'd2
   } eng_state_e;

   localparam int CTRL_RUN = 0;
   localparam int CTRL_PP  = 1;
   localparam int CTRL_HIP = 2;
endpackage

// File: rtl/dma6_chan.sv
module dma6_chan
   import dma6_pkg::*;
#(
   parameter int AW      = 16,
   parameter int CW      = 8,
   parameter bit PRIO_OK = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [3:0]    cfg_field,
   input  logic [AW-1:0] cfg_wdata,
   input  logic          trig,
   input  logic          step,
   output logic [AW-1:0] src_addr,
   output logic [AW-1:0] dst_addr,
   output logic          last,
   output logic          req,
   output logic          mid,
   output logic          hip,
   output logic          ovf,
   output logic          irq
);
   logic [AW-1:0] src_base, dst_base, dst_alt;
   logic [AW-1:0] s_wstep, d_wstep, s_bstep, d_bstep;
   logic [AW-1:0] sb, db, sc, dc;
   logic [CW-1:0] bsize, tcount, wcnt, tleft;
   logic          armed, pp, pend, ovf_q, irq_q, use_alt;
   logic          trig_any, ctrl_wr;

   assign trig_any = trig | (cfg_we && cfg_field == F_TRIG);
   assign ctrl_wr  = cfg_we && cfg_field == F_CTRL;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_base <= '0; dst_base <= '0; dst_alt <= '0;
         s_wstep <= '0; d_wstep <= '0; s_bstep <= '0; d_bstep <= '0;
         sb <= '0; db <= '0; sc <= '0; dc <= '0;
         bsize <= '0; tcount <= '0; wcnt <= '0; tleft <= '0;
         armed <= 1'b0; pp <= 1'b0; pend <= 1'b0;
         ovf_q <= 1'b0; irq_q <= 1'b0; use_alt <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (step) begin
            if (wcnt == bsize) begin
               wcnt <= '0;
               pend <= 1'b0;
               if (tleft == CW'(1)) begin
                  irq_q <= 1'b1;
                  if (pp) begin
                     tleft   <= tcount;
                     use_alt <= !use_alt;
                     sb <= src_base; sc <= src_base;
                     db <= use_alt ? dst_base : dst_alt;
                     dc <= use_alt ? dst_base : dst_alt;
                  end else begin
                     armed <= 1'b0;
                     tleft <= '0;
                  end
               end else begin
                  tleft <= tleft - CW'(1);
                  sb <= sb + s_bstep; sc <= sb + s_bstep;
                  db <= db + d_bstep; dc <= db + d_bstep;
               end
            end else begin
               wcnt <= wcnt + CW'(1);
               sc   <= sc + s_wstep;
               dc   <= dc + d_wstep;
            end
         end
         if (trig_any) begin
            if (pend)       ovf_q <= 1'b1;
            else if (armed) pend  <= 1'b1;
         end
         if (cfg_we) begin
            case (cfg_field)
               F_SRC:    src_base <= cfg_wdata;
               F_DST:    dst_base <= cfg_wdata;
               F_DALT:   dst_alt  <= cfg_wdata;
               F_BSIZE:  bsize    <= cfg_wdata[CW-1:0];
               F_TCOUNT: tcount   <= cfg_wdata[CW-1:0];
               F_SBSTEP: s_wstep  <= cfg_wdata;
               F_DBSTEP: d_wstep  <= cfg_wdata;
               F_STSTEP: s_bstep  <= cfg_wdata;
               F_DTSTEP: d_bstep  <= cfg_wdata;
               F_CTRL: begin
                  armed   <= cfg_wdata[CTRL_RUN] && (tcount != '0);
                  pp      <= cfg_wdata[CTRL_PP];
                  ovf_q   <= 1'b0;
                  pend    <= 1'b0;
                  use_alt <= 1'b0;
                  wcnt    <= '0;
                  tleft   <= tcount;
                  sb <= src_base; sc <= src_base;
                  db <= dst_base; dc <= dst_base;
               end
               default: ;
            endcase
         end
      end
   end

   generate
      if (PRIO_OK) begin : g_prio
         logic hip_q;
         always_ff @(posedge clk) begin
            if (!rst_n)       hip_q <= 1'b0;
            else if (ctrl_wr) hip_q <= cfg_wdata[CTRL_HIP];
         end
         assign hip = hip_q;
      end else begin : g_noprio
         assign hip = 1'b0;
      end
   endgenerate

   assign src_addr = sc;
   assign dst_addr = dc;
   assign last     = (wcnt == bsize);
   assign req      = pend;
   assign mid      = pend && (wcnt != '0);
   assign ovf      = ovf_q;
   assign irq      = irq_q;

   // R8: the overflow flag only drops on a control write
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !ctrl_wr) |=> ovf_q);
endmodule

// File: rtl/dma6_arb.sv
module dma6_arb #(
   parameter int NCH = 6,
   localparam int IW = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] req,
   input  logic [NCH-1:0] mid,
   input  logic           hip0,
   input  logic           adv,
   input  logic [IW-1:0]  adv_idx,
   output logic           gnt_vld,
   output logic [IW-1:0]  gnt_idx
);
   logic [IW-1:0] ptr;
   logic          found;

   always_ff @(posedge clk) begin
      if (!rst_n)   ptr <= IW'(NCH - 1);
      else if (adv) ptr <= adv_idx;
   end

   always_comb begin
      gnt_idx = '0;
      found   = 1'b0;
      if (hip0 && req[0]) found = 1'b1;
      for (int i = 0; i < NCH; i++) begin
         if (!found && mid[i]) begin
            gnt_idx = IW'(i);
            found   = 1'b1;
         end
      end
      for (int k = 1; k <= NCH; k++) begin
         if (!found && req[(int'(ptr) + k) % NCH]) begin
            gnt_idx = IW'((int'(ptr) + k) % NCH);
            found   = 1'b1;
         end
      end
   end

   assign gnt_vld = |req;

   // R9: a grant always names a channel that is pending
   a_r9_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld |-> req[gnt_idx]);
endmodule

// File: rtl/dma_nested6.sv
module dma_nested6
   import dma6_pkg::*;
#(
   parameter int NCH = 6,
   parameter int AW  = 16,
   parameter int DW  = 16,
   parameter int CW  = 8,
   localparam int IW = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [IW-1:0]  cfg_ch,
   input  logic [3:0]     cfg_field,
   input  logic [AW-1:0]  cfg_wdata,
   input  logic [NCH-1:0] trig_in,
   output logic           m_valid,
   output logic           m_write,
   output logic [AW-1:0]  m_addr,
   output logic [DW-1:0]  m_wdata,
   input  logic           m_ready,
   input  logic [DW-1:0]  m_rdata,
   output logic [NCH-1:0] irq,
   output logic [NCH-1:0] ovf
);
   generate
      if (NCH < 2 || NCH > 16) begin : g_bad_nch
         $error("dma_nested6: NCH must lie in 2..16");
      end
      if (CW > AW) begin : g_bad_cw
         $error("dma_nested6: CW must not exceed AW");
      end
   endgenerate

   logic [AW-1:0]  src_a [NCH];
   logic [AW-1:0]  dst_a [NCH];
   logic [NCH-1:0] last_w, req_w, mid_w, hip_w, step_w;
   logic           gnt_vld, burst_end;
   logic [IW-1:0]  gnt_idx, cur;
   logic [DW-1:0]  data_q;
   eng_state_e     state;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      dma6_chan #(.AW(AW), .CW(CW), .PRIO_OK(i == 0)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (cfg_we && cfg_ch == IW'(i)),
         .cfg_field(cfg_field),
         .cfg_wdata(cfg_wdata),
         .trig     (trig_in[i]),
         .step     (step_w[i]),
         .src_addr (src_a[i]),
         .dst_addr (dst_a[i]),
         .last     (last_w[i]),
         .req      (req_w[i]),
         .mid      (mid_w[i]),
         .hip      (hip_w[i]),
         .ovf      (ovf[i]),
         .irq      (irq[i])
      );
      assign step_w[i] = (state == S_WR) && m_ready && (cur == IW'(i));
   end

   assign burst_end = (state == S_WR) && m_ready && last_w[cur];

   dma6_arb #(.NCH(NCH)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req_w),
      .mid    (mid_w),
      .hip0   (hip_w[0]),
      .adv    (burst_end),
      .adv_idx(cur),
      .gnt_vld(gnt_vld),
      .gnt_idx(gnt_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         cur    <= '0;
         data_q <= '0;
      end else begin
         case (state)
            S_IDLE: if (gnt_vld) begin
               cur   <= gnt_idx;
               state <= S_RD;
            end
            S_RD: if (m_ready) begin
               data_q <= m_rdata;
               state  <= S_WR;
            end
            S_WR: if (m_ready) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign m_valid = (state != S_IDLE);
   assign m_write = (state == S_WR);
   assign m_addr  = m_write ? dst_a[cur] : src_a[cur];
   assign m_wdata = data_q;

   // R3: an accepted read is followed by a write of that data
   a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_write && m_ready) |=> (m_valid && m_write && m_wdata == $past(m_rdata)));

   // R12: a stalled access holds its request
   a_r12_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_write) && $stable(m_addr) && $stable(m_wdata)));

   // R13: completion pulses never overlap
   a_r13_irq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq));

   // R10: boosted channel 0 wins the next word slot
   a_r10_boost_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && hip_w[0] && req_w[0]) |=> (state == S_RD && cur == '0));
endmodule

// File: tb/dma_nested6_bench.sv
module dma_nested6_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_ch = '0;
   logic [3:0]  cfg_field = '0;
   logic [15:0] cfg_wdata = '0;
   logic [5:0]  trig_in = '0;
   logic        m_valid, m_write, m_ready;
   logic [15:0] m_addr, m_wdata, m_rdata;
   logic [5:0]  irq, ovf;

   int errors = 0;
   int checks = 0;

   logic [15:0] mem   [1024];
   logic [15:0] wlog  [512];
   logic [15:0] rlog  [512];
   int          wn, rn, multi_irq;
   int          irq_cnt [6];

   always #2 clk = ~clk;

   dma_nested6 u_dma_nested6 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
      .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .trig_in(trig_in),
      .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
      .m_ready(m_ready), .m_rdata(m_rdata), .irq(irq), .ovf(ovf)
   );

   assign m_rdata = mem[m_addr[9:0]];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 1024; i++) mem[i] <= 16'hC000 + 16'(i);
         wn <= 0; rn <= 0; multi_irq <= 0;
         for (int i = 0; i < 6; i++) irq_cnt[i] <= 0;
      end else begin
         if (m_valid && m_ready && m_write) begin
            mem[m_addr[9:0]] <= m_wdata;
            wlog[wn % 512] <= m_addr;
            wn <= wn + 1;
         end
         if (m_valid && m_ready && !m_write) begin
            rlog[rn % 512] <= m_addr;
            rn <= rn + 1;
         end
         for (int i = 0; i < 6; i++) if (irq[i]) irq_cnt[i] <= irq_cnt[i] + 1;
         if ($countones(irq) > 1) multi_irq <= multi_irq + 1;
      end
   end

   function automatic logic [15:0] pat(input int a);
      return 16'hC000 + 16'(a);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cfg(input int ch, input int field, input int val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_field = 4'(field); cfg_wdata = 16'(val);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic setup(input int ch, input int src, input int dst, input int alt,
                        input int bsz, input int tc, input int sw, input int dw,
                        input int sbs, input int dbs, input int ctrl);
      cfg(ch, 0, src); cfg(ch, 1, dst); cfg(ch, 2, alt);
      cfg(ch, 3, bsz); cfg(ch, 4, tc);
      cfg(ch, 5, sw);  cfg(ch, 6, dw); cfg(ch, 7, sbs); cfg(ch, 8, dbs);
      cfg(ch, 9, ctrl);
   endtask

   task automatic hw_trig(input logic [5:0] mask);
      @(negedge clk);
      trig_in = mask;
      @(negedge clk);
      trig_in = '0;
   endtask

   task automatic quiet();
      int q = 0;
      while (q < 6) begin
         @(negedge clk);
         if (m_valid) q = 0; else q++;
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 irq", int'(irq), 0);
      check("R1 ovf", int'(ovf), 0);
      check("R1 m_valid", int'(m_valid), 0);
   endtask

   task automatic t_basic();
      int base;
      // R2: zero count leaves channel unarmed
      setup(2, 200, 250, 0, 0, 0, 1, 1, 0, 0, 1);
      base = wn;
      hw_trig(6'b000100);
      quiet();
      check("R2 unarmed no traffic", wn - base, 0);
      // ch1: 3-word bursts, dst word step 2, burst steps 10/16
      setup(1, 100, 300, 0, 2, 2, 1, 2, 10, 16, 1);
      base = wn;
      hw_trig(6'b000010);
      quiet();
      check("R3 words per burst", wn - base, 3);
      check("R3 first word", int'(mem[300]), int'(pat(100)));
      check("R4 word step dst+2", int'(mem[302]), int'(pat(101)));
      check("R4 third word", int'(mem[304]), int'(pat(102)));
      check("R6 no irq mid transfer", irq_cnt[1], 0);
      cfg(1, 10, 0);                         // R7 software trigger
      quiet();
      check("R7 sw trigger moves burst", wn - base, 6);
      check("R5 burst step start", int'(mem[316]), int'(pat(110)));
      check("R5 burst step last", int'(mem[320]), int'(pat(112)));
      check("R6 irq once at end", irq_cnt[1], 1);
      base = wn;
      hw_trig(6'b000010);
      quiet();
      check("R6 disarmed ignores trigger", wn - base, 0);
      // R4 negative destination step
      setup(3, 400, 520, 0, 1, 1, 1, 16'hFFFF, 0, 0, 1);
      hw_trig(6'b001000);
      quiet();
      check("R4 neg step first", int'(mem[520]), int'(pat(400)));
      check("R4 neg step second", int'(mem[519]), int'(pat(401)));
   endtask

   task automatic t_overflow();
      int base;
      setup(2, 200, 250, 0, 3, 3, 1, 1, 4, 4, 1);
      base = wn;
      hw_trig(6'b000100);
      hw_trig(6'b000100);
      quiet();
      check("R8 ovf set on retrigger", int'(ovf[2]), 1);
      check("R8 retrigger not queued", wn - base, 4);
      cfg(2, 9, 1);
      @(negedge clk);
      check("R8 ctrl write clears ovf", int'(ovf[2]), 0);
      // collision: trigger in the cycle the last write is accepted
      setup(4, 220, 270, 0, 0, 3, 1, 1, 1, 1, 1);
      base = wn;
      hw_trig(6'b010000);
      do @(negedge clk); while (!(m_valid && m_write && m_addr == 16'd270));
      trig_in = 6'b010000;
      @(negedge clk);
      trig_in = '0;
      quiet();
      check("R8 collision sets ovf", int'(ovf[4]), 1);
      check("R8 collision moves one word", wn - base, 1);
      check("R6 no irq before count ends", irq_cnt[4], 0);
   endtask

   task automatic t_round_robin();
      int base;
      setup(2, 200, 640, 0, 0, 1, 1, 1, 0, 0, 1);
      hw_trig(6'b000100);
      quiet();
      setup(1, 150, 600, 0, 1, 1, 1, 1, 0, 0, 1);
      setup(3, 160, 610, 0, 1, 1, 1, 1, 0, 0, 1);
      setup(5, 170, 620, 0, 1, 1, 1, 1, 0, 0, 1);
      base = wn;
      hw_trig(6'b101010);
      quiet();
      check("R9 count", wn - base, 6);
      check("R9 order 0", int'(wlog[base + 0]), 610);
      check("R9 order 1", int'(wlog[base + 1]), 611);
      check("R9 order 2", int'(wlog[base + 2]), 620);
      check("R9 order 3", int'(wlog[base + 3]), 621);
      check("R9 order 4", int'(wlog[base + 4]), 600);
      check("R9 order 5", int'(wlog[base + 5]), 601);
   endtask

   task automatic t_boost();
      int base, i0, i1;
      i0 = irq_cnt[0];
      i1 = irq_cnt[1];
      setup(0, 180, 700, 0, 0, 1, 1, 1, 0, 0, 5);
      setup(1, 190, 710, 0, 3, 1, 1, 1, 0, 0, 1);
      base = wn;
      hw_trig(6'b000010);
      do @(negedge clk); while (!(m_valid && m_write && m_addr == 16'd710));
      trig_in = 6'b000001;
      @(negedge clk);
      trig_in = '0;
      quiet();
      check("R10 first ch1 word", int'(wlog[base + 0]), 710);
      check("R10 ch0 preempts", int'(wlog[base + 1]), 700);
      check("R10 ch1 resumes", int'(wlog[base + 2]), 711);
      check("R10 ch1 finishes", int'(wlog[base + 4]), 713);
      check("R10 ch0 data", int'(mem[700]), int'(pat(180)));
      check("R10 ch1 data", int'(mem[713]), int'(pat(193)));
      check("R10 both complete", (irq_cnt[0] - i0) + (irq_cnt[1] - i1), 2);
   endtask

   task automatic t_pingpong();
      int base, rb, ic;
      ic = irq_cnt[5];
      setup(5, 800, 840, 860, 1, 1, 1, 1, 0, 0, 3);
      base = wn;
      hw_trig(6'b100000);
      quiet();
      check("R11 first dst", int'(mem[841]), int'(pat(801)));
      hw_trig(6'b100000);
      quiet();
      check("R11 alt dst", int'(mem[860]), int'(pat(800)));
      check("R11 still armed", wn - base, 4);
      rb = rn;
      hw_trig(6'b100000);
      quiet();
      check("R11 back to first dst", int'(wlog[base + 4]), 840);
      check("R11 source reloaded", int'(rlog[rb]), 800);
      check("R11 irq per transfer", irq_cnt[5] - ic, 3);
   endtask

   task automatic t_stall();
      logic [7:0] lf = 8'hA5;
      setup(3, 900, 950, 0, 4, 2, 1, 1, 5, 5, 1);
      fork
         begin
            for (int k = 0; k < 200; k++) begin
               @(negedge clk);
               lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
               m_ready = lf[0];
            end
            @(negedge clk);
            m_ready = 1'b1;
         end
         begin
            hw_trig(6'b001000);
            repeat (80) @(negedge clk);
            hw_trig(6'b001000);
         end
      join
      quiet();
      for (int k = 0; k < 10; k++)
         check("R12 stalled copy", int'(mem[950 + k]), int'(pat(900 + k)));
   endtask

   initial begin
      m_ready = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_overflow();
      t_round_robin();
      t_boost();
      t_pingpong();
      t_stall();
      check("R13 irq overlap cycles", multi_irq, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule